// File: doc/BRIEF.md
# Associative Rename Buffer File

This block keeps renamed copies of destination registers in a small circular buffer that sits next to a separate architectural register file. Each instruction that enters rename is given a fresh buffer entry at the head pointer. The entry is tagged with the destination register number and marked as the newest instance of that register. When an entry is allocated, any older entry for the same register loses its newest mark.

Each instruction has two source registers. In the same cycle as the allocation, both are looked up by content. A source that maps to a computed newest entry returns its value. A source that maps to an uncomputed newest entry returns the entry index as a tag. A source with no newest entry in the buffer returns the architectural value. Execution units write results back by tag. In-order retirement copies the tail entry into the architectural file and frees it by moving the tail forward. One instruction is renamed per cycle, which matches the issue rate.

The rename request is a valid/ready stream. `ren_ready` is low only while every entry is occupied. A request offered while `ren_ready` is low is not taken, and it must be held until accepted. Sources are read from the state before the same cycle's allocation.

Retirement is also a valid/ready stream. `ret_ready` is high only when the tail entry is occupied and its result has been computed, and `ret_valid` is ignored while `ret_ready` is low. Result writes are plain inputs that are always accepted.

Top module: `rnb_rename_file`

## Requirements
- R1: After reset the buffer is empty. `ren_ready` is 1, `ret_ready` is 0, and every source lookup returns available (`opX_avail`=1) with architectural value 0.
- R2: An accepted rename takes the entry at the head. `ren_tag` gives that index. Successive accepted renames get indices 0,1,2,… modulo DEPTH, wrapping from DEPTH-1 to 0.
- R3: A source whose newest buffer entry has no result yet returns `opX_avail`=0 and `opX_tag` equal to that entry's index.
- R4: When several occupied entries hold the same register, a lookup uses only the most recently allocated one. When no newest entry matches, the architectural value is used.
- R5: A result write (`wb_valid`, `wb_tag`, `wb_data`) to an occupied entry stores the value. Later lookups that hit that entry return `opX_avail`=1 with that value.
- R6: A result write in the same cycle as a lookup that hits the written, still-pending entry returns `opX_avail`=1 with `wb_data` in that cycle.
- R7: Source lookups see the state before the same cycle's allocation. A source equal to the destination returns the previous instance.
- R8: `ret_ready` is 1 only when the tail entry holds a computed result. A retirement writes that value into the architectural register and frees the entry. A later lookup of that register with no newest entry left returns the retired value.
- R9: With all DEPTH entries occupied, `ren_ready` is 0. A request offered then allocates nothing, so the next accepted rename receives the index that follows the last accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Free entry available, request taken |
| ren_dst | input | $clog2(NREG) | Destination register |
| ren_src_a | input | $clog2(NREG) | First source register |
| ren_src_b | input | $clog2(NREG) | Second source register |
| ren_tag | output | $clog2(DEPTH) | Entry index given to the destination |
| opa_avail | output | 1 | First source value available |
| opa_data | output | DATA_W | First source value (0 when pending) |
| opa_tag | output | $clog2(DEPTH) | First source pending entry index |
| opb_avail | output | 1 | Second source value available |
| opb_data | output | DATA_W | Second source value (0 when pending) |
| opb_tag | output | $clog2(DEPTH) | Second source pending entry index |
| wb_valid | input | 1 | Result write present |
| wb_tag | input | $clog2(DEPTH) | Entry receiving the result |
| wb_data | input | DATA_W | Result value |
| ret_valid | input | 1 | Retire request for the tail entry |
| ret_ready | output | 1 | Tail entry computed and retirable |

## Verification
The bench builds the block with DEPTH=4, NREG=8 and DATA_W=16, so DEPTH must be a power of two. A four-entry buffer fills after four renames. Index wraparound from 3 to 0 and the full-buffer stall with an ignored request are therefore reached within a dozen cycles. Eight registers leave room for two live instances of one register next to unrelated ones. This exercises newest-instance selection, reads before same-cycle allocation, result bypass and the fallback to the architectural value after retirement.

// File: rtl/rnb_pkg.sv
package rnb_pkg;
  // Index of the highest set bit of a match vector (at most one is expected).
  function automatic int unsigned oh_index(input logic [63:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 64; i++) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/rnb_arch_file.sv
module rnb_arch_file #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RW-1:0]     rd_a_reg,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [RW-1:0]     rd_b_reg,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [NREG-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (wr_en && wr_reg == RW'(g)) regs[g] <= wr_data;
    end
  end

  assign rd_a_data = regs[rd_a_reg];
  assign rd_b_data = regs[rd_b_reg];
endmodule

// File: rtl/rnb_lookup.sv
module rnb_lookup #(
  parameter int DEPTH  = 8,
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0]             busy,
  input  logic [DEPTH-1:0]             latest,
  input  logic [DEPTH-1:0]             done,
  input  logic [DEPTH-1:0][RW-1:0]     ent_reg,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [RW-1:0]                src,
  input  logic [DATA_W-1:0]            arch_val,
  input  logic                         wb_valid,
  input  logic [IW-1:0]                wb_tag,
  input  logic [DATA_W-1:0]            wb_data,
  output logic                         avail,
  output logic [DATA_W-1:0]            val,
  output logic [IW-1:0]                tag
);
  logic [DEPTH-1:0] match;
  logic [IW-1:0]    idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = busy[g] && latest[g] && (ent_reg[g] == src);
  end

  assign idx = IW'(rnb_pkg::oh_index(64'(match)));

  always_comb begin
    avail = 1'b1;
    val   = arch_val;
    tag   = '0;
    if (|match) begin
      if (done[idx]) begin
        val = ent_data[idx];
      end else if (wb_valid && wb_tag == idx) begin
        val = wb_data;
      end else begin
        avail = 1'b0;
        val   = '0;
        tag   = idx;
      end
    end
  end

  // R4: at most one newest occupied entry per register
  a_r4_single_latest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/rnb_rename_file.sv
module rnb_rename_file #(
  parameter int DEPTH  = 8,
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG),
  localparam int PW = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  output logic              ren_ready,
  input  logic [RW-1:0]     ren_dst,
  input  logic [RW-1:0]     ren_src_a,
  input  logic [RW-1:0]     ren_src_b,
  output logic [IW-1:0]     ren_tag,
  output logic              opa_avail,
  output logic [DATA_W-1:0] opa_data,
  output logic [IW-1:0]     opa_tag,
  output logic              opb_avail,
  output logic [DATA_W-1:0] opb_data,
  output logic [IW-1:0]     opb_tag,
  input  logic              wb_valid,
  input  logic [IW-1:0]     wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              ret_valid,
  output logic              ret_ready
);
  logic [PW-1:0]                head, tail, count;
  logic [IW-1:0]                head_idx, tail_idx;
  logic [DEPTH-1:0]             busy, latest, done;
  logic [DEPTH-1:0][RW-1:0]     ent_reg;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic                         ren_fire, ret_fire;
  logic [DATA_W-1:0]            arch_a, arch_b;

  assign head_idx  = head[IW-1:0];
  assign tail_idx  = tail[IW-1:0];
  assign count     = head - tail;
  assign ren_ready = (count != PW'(DEPTH));
  assign ren_fire  = ren_valid && ren_ready;
  assign ren_tag   = head_idx;
  assign ret_ready = busy[tail_idx] && done[tail_idx];
  assign ret_fire  = ret_valid && ret_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (ren_fire) head <= head + PW'(1);
      if (ret_fire) tail <= tail + PW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[g]     <= 1'b0;
        latest[g]   <= 1'b0;
        done[g]     <= 1'b0;
        ent_reg[g]  <= '0;
        ent_data[g] <= '0;
      end else begin
        if (wb_valid && wb_tag == IW'(g) && busy[g]) begin
          ent_data[g] <= wb_data;
          done[g]     <= 1'b1;
        end
        if (ret_fire && tail_idx == IW'(g)) begin
          busy[g]   <= 1'b0;
          latest[g] <= 1'b0;
        end
        if (ren_fire) begin
          if (head_idx == IW'(g)) begin
            busy[g]    <= 1'b1;
            latest[g]  <= 1'b1;
            done[g]    <= 1'b0;
            ent_reg[g] <= ren_dst;
          end else if (busy[g] && ent_reg[g] == ren_dst) begin
            latest[g] <= 1'b0;
          end
        end
      end
    end

    // R5: a computed entry keeps its result until it is freed
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && done[g] && !(ret_fire && tail_idx == IW'(g))) |=> done[g]);
  end

  rnb_arch_file #(.NREG(NREG), .DATA_W(DATA_W)) u_arch (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ret_fire), .wr_reg(ent_reg[tail_idx]), .wr_data(ent_data[tail_idx]),
    .rd_a_reg(ren_src_a), .rd_a_data(arch_a),
    .rd_b_reg(ren_src_b), .rd_b_data(arch_b)
  );

  rnb_lookup #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W)) u_look_a (
    .clk(clk), .rst_n(rst_n), .busy(busy), .latest(latest), .done(done),
    .ent_reg(ent_reg), .ent_data(ent_data), .src(ren_src_a), .arch_val(arch_a),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .avail(opa_avail), .val(opa_data), .tag(opa_tag)
  );

  rnb_lookup #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W)) u_look_b (
    .clk(clk), .rst_n(rst_n), .busy(busy), .latest(latest), .done(done),
    .ent_reg(ent_reg), .ent_data(ent_data), .src(ren_src_b), .arch_val(arch_b),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .avail(opb_avail), .val(opb_data), .tag(opb_tag)
  );

  // R9: occupancy never exceeds the buffer size
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));
  // R2: each accepted rename moves the head by exactly one
  a_r2_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |=> head == $past(head) + PW'(1));
  // R8: each retirement moves the tail by exactly one
  a_r8_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> tail == $past(tail) + PW'(1));
endmodule

// File: tb/rnb_rename_file_tb.sv
module rnb_rename_file_tb;
  localparam int DEPTH = 4, NREG = 8, DW = 16, IW = 2, RW = 3;

  logic clk, rst_n;
  logic ren_valid, ren_ready, wb_valid, ret_valid, ret_ready;
  logic [RW-1:0] ren_dst, ren_src_a, ren_src_b;
  logic [IW-1:0] ren_tag, opa_tag, opb_tag, wb_tag;
  logic opa_avail, opb_avail;
  logic [DW-1:0] opa_data, opb_data, wb_data;

  rnb_rename_file #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_dst(ren_dst), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_tag(ren_tag),
    .opa_avail(opa_avail), .opa_data(opa_data), .opa_tag(opa_tag),
    .opb_avail(opb_avail), .opb_data(opb_data), .opb_tag(opb_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .ret_valid(ret_valid), .ret_ready(ret_ready));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { string req; int kind; int exp; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  bit m_busy[DEPTH], m_latest[DEPTH], m_done[DEPTH];
  int m_reg[DEPTH], m_data[DEPTH], m_arch[NREG];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  function automatic int actual(int k);
    case (k)
      0: return int'(ren_ready);
      1: return int'(ret_ready);
      2: return int'(ren_tag);
      3: return int'(opa_avail);
      4: return int'(opa_data);
      5: return int'(opa_tag);
      6: return int'(opb_avail);
      7: return int'(opb_data);
      default: return int'(opb_tag);
    endcase
  endfunction

  task automatic push(string r, int k, int e);
    item_t it;
    it.req = r; it.kind = k; it.exp = e;
    q.push_back(it);
  endtask

  task automatic exp_lookup(input int src, input bit wv, input int wt, input int wd,
                            output int av, output int val, output int tg);
    av = 1; val = m_arch[src]; tg = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_busy[i] && m_latest[i] && m_reg[i] == src) begin
        if (m_done[i]) val = m_data[i];
        else if (wv && wt == i) val = wd;
        else begin av = 0; val = 0; tg = i; end
      end
    end
  endtask

  task automatic step(string req, bit rv, int dst, int sa, int sb,
                      bit wv, int wt, int wd, bit tv);
    int av, val, tg;
    bit can_ren, can_ret;
    @(posedge clk); #1;
    ren_valid = rv; ren_dst = RW'(dst); ren_src_a = RW'(sa); ren_src_b = RW'(sb);
    wb_valid = wv; wb_tag = IW'(wt); wb_data = DW'(wd); ret_valid = tv;
    can_ren = (m_cnt < DEPTH);
    can_ret = m_busy[m_tail] && m_done[m_tail];
    push(req, 0, int'(can_ren));
    push(req, 1, int'(can_ret));
    if (can_ren) push(req, 2, m_head);
    exp_lookup(sa, wv, wt, wd, av, val, tg);
    push(req, 3, av); push(req, 4, val); if (!av) push(req, 5, tg);
    exp_lookup(sb, wv, wt, wd, av, val, tg);
    push(req, 6, av); push(req, 7, val); if (!av) push(req, 8, tg);
    // next-state of the model
    if (wv && m_busy[wt]) begin m_data[wt] = wd; m_done[wt] = 1; end
    if (tv && can_ret) begin
      m_arch[m_reg[m_tail]] = m_data[m_tail];
      m_busy[m_tail] = 0; m_latest[m_tail] = 0;
      m_tail = (m_tail + 1) % DEPTH; m_cnt--;
    end
    if (rv && can_ren) begin
      for (int i = 0; i < DEPTH; i++)
        if (m_busy[i] && m_reg[i] == dst) m_latest[i] = 0;
      m_busy[m_head] = 1; m_latest[m_head] = 1; m_done[m_head] = 0; m_reg[m_head] = dst;
      m_head = (m_head + 1) % DEPTH; m_cnt++;
    end
  endtask

  // monitor: compares everything queued for this cycle, mid-period
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (actual(it.kind) !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind,
                 actual(it.kind), it.exp);
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_busy[i] = 0; m_latest[i] = 0; m_done[i] = 0; m_reg[i] = 0; m_data[i] = 0;
    end
    for (int i = 0; i < NREG; i++) m_arch[i] = 0;
    rst_n = 0; ren_valid = 0; ren_dst = '0; ren_src_a = '0; ren_src_b = '0;
    wb_valid = 0; wb_tag = '0; wb_data = '0; ret_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    //   req      rv dst sa sb  wv wt wd     tv
    step("R1 reset",  0, 0, 3, 5, 0, 0, 0,     0);
    step("R2 alloc0", 1, 2, 0, 1, 0, 0, 0,     0);
    step("R3 pend",   1, 3, 2, 1, 0, 0, 0,     0);
    step("R7 before", 1, 2, 2, 3, 0, 0, 0,     0);
    step("R4 newest", 0, 0, 2, 3, 0, 0, 0,     0);
    step("R8 notrdy", 0, 0, 3, 2, 1, 0, 'h11,  1);
    step("R6 bypass", 0, 0, 2, 3, 1, 2, 'h22,  0);
    step("R5 value",  0, 0, 2, 3, 1, 1, 'h33,  1);
    step("R2 alloc3", 1, 5, 2, 3, 0, 0, 0,     0);
    step("R2 wrap0",  1, 6, 5, 6, 0, 0, 0,     0);
    step("R9 full",   1, 7, 6, 7, 0, 0, 0,     0);
    step("R8 retire", 0, 0, 3, 7, 0, 0, 0,     1);
    step("R9 resume", 1, 7, 3, 7, 0, 0, 0,     0);
    step("R8 arch",   0, 0, 2, 7, 0, 0, 0,     1);
    step("R4 arch",   0, 0, 2, 3, 1, 3, 'h55,  0);
    @(posedge clk); #1;
    ren_valid = 0; wb_valid = 0; ret_valid = 0;
    repeat (2) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule